// File: doc/BRIEF.md
# Dual-Channel Timer Capture/Compare Unit

This block pairs two timer channels with one free-running up-counter. The counter counts from zero up to a programmable modulo value and then wraps to zero. Software can halt the counter or zero it. Each channel is set up through its own control register. A channel can timestamp edges on its pin (input capture). It can drive its pin on a counter match (output compare/PWM). It can also let go of its pin so that other logic can use it as plain I/O. Channel 0 can also take over channel 1. In that mode the two value registers act as a ping-pong pair of compare values, and new compare values take effect only at a counter wrap.

Software reaches the block through a small register port. Writes are synchronous and reads are combinational. The word address selects one of these registers:

| Address | Register |
|---|---|
| 0 | counter control: bit 0 halts the counter, bit 1 zeroes it |
| 1 | modulo |
| 2 | counter value, read only |
| 3 | channel 0 control |
| 4 | channel 0 value |
| 5 | channel 1 control |
| 6 | channel 1 value |

Both control registers use the same fields:

| Bits | Field |
|---|---|
| [1:0] | edge/level field |
| [2] | mode bit |
| [3] | buffered-mode bit, channel 0 only |
| [4] | interrupt enable |
| [5] | event flag |

Each channel has one pin input, one pin output with an output enable, and one interrupt request.

Top module: `dual_capcmp_timer`

## Requirements
- R1: After reset, all of the following hold. Both control registers and both value registers read 0. The counter-control register reads 0. The modulo reads all ones. Both output enables and both interrupt requests are low.
- R2: When the counter is not halted, it adds one on each clock. On the clock where its value equals the modulo, it goes to 0 instead.
- R3: Writing 1 to bit 0 of address 0 halts the counter, and the counter then holds its value. Writing 1 to bit 1 of address 0 zeroes the counter. Bit 1 always reads back as 0.
- R4: When a channel's edge/level field is 00, the channel lets go of its pin and the output enable is low. One clock after the field becomes 00, the pin output level follows the mode bit: mode bit 1 gives a low level and mode bit 0 gives a high level.
- R5: When the edge/level field is nonzero and the mode bit is 0, the channel is in input capture and its output enable is low. The pin passes through two synchronizing flops. The field then selects the active edge: 01 is rising, 10 is falling and 11 is both edges. On an active edge, the value register takes the counter value and the event flag (bit 5) is set.
- R6: When the edge/level field is nonzero and the mode bit is 1, the channel is in output compare and its output enable is high. A match is the clock on which the counter advances from a value equal to the compare value. On a match the flag is set and the pin is driven by the field: 01 toggles the pin, 10 drives it low and 11 drives it high.
- R7: The event flag clears only under one sequence. Software first reads the control register while the flag is set. The next write to that register must then have bit 5 at 0. A write with bit 5 at 0 that does not follow such a read leaves the flag set.
- R8: A channel's interrupt request is high exactly when both its flag and its interrupt enable (bit 4) are set.
- R9: While bit 3 of channel 0 is set, channel 1 is inactive: writes to its control register are ignored, its output enable is low, and it raises no events.
- R10: When bit 3 is set and channel 0's field is nonzero, channel 0 is in buffered compare mode. Entering the mode, it compares against channel 0's value register. At each wrap, it switches to the other value register, alternating between channel 1's and channel 0's. The value it switches to is the one held at that wrap, so a write made before the wrap takes effect only at the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; it arms the flag clear |
| addr | input | AW | Register word address |
| wdata | input | CW | Write data |
| rdata | output | CW | Read data, combinational from addr |
| pin_in | input | 2 | Channel pin inputs |
| pin_out | output | 2 | Channel pin output levels |
| pin_oe | output | 2 | Channel pin output enables |
| irq | output | 2 | Per-channel interrupt requests |

## Verification
The assertions check the counter on every cycle: its step, its wrap at the modulo, its hold while halted and its zeroing. They also check three other things each clock: the pin level that follows the mode bit when the edge/level field is 00, that a flag set without an armed read stays set, and that channel 1 stays silent under buffered mode. Other behaviours need the bench's scenarios. These are the choice of active edge for capture, the value latched at capture, the three compare pin actions, and the interrupt gating. The bench also checks the buffered ping-pong through the pin level after a set number of counter steps, and it shows that a value write made before a wrap has no effect until the wrap.

// File: rtl/dual_capcmp_timer.sv
module dual_capcmp_timer #(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  input  logic [1:0]    pin_in,
  output logic [1:0]    pin_out,
  output logic [1:0]    pin_oe,
  output logic [1:0]    irq
);
  localparam logic [AW-1:0] A_CTL  = AW'(0);
  localparam logic [AW-1:0] A_MOD  = AW'(1);
  localparam logic [AW-1:0] A_CNT  = AW'(2);
  localparam logic [AW-1:0] A_SC0  = AW'(3);
  localparam logic [AW-1:0] A_VAL0 = AW'(4);
  localparam logic [AW-1:0] A_SC1  = AW'(5);
  localparam logic [AW-1:0] A_VAL1 = AW'(6);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic [CW-1:0] cnt, modv, act;
  logic stop, bsel, buf_en;
  logic [1:0][1:0] els;
  logic [1:0] msa, ie, flag, arm, outq;
  logic [1:0][CW-1:0] val, cmpv;
  logic [1:0][2:0] sy;
  logic [1:0] wr_sc, rd_sc, wr_val, live, cap_on, cmp_on, hit;

  wire clr  = wr_en && addr == A_CTL && wdata[1];
  wire tick = !stop && !clr;
  wire wrap = cnt == modv;
  wire bufm = buf_en && els[0] != 2'b00;

  always_comb begin
    wr_sc[0]  = wr_en && addr == A_SC0;
    wr_sc[1]  = wr_en && addr == A_SC1 && !buf_en;
    rd_sc[0]  = rd_en && addr == A_SC0;
    rd_sc[1]  = rd_en && addr == A_SC1 && !buf_en;
    wr_val[0] = wr_en && addr == A_VAL0;
    wr_val[1] = wr_en && addr == A_VAL1;
    live[0]   = els[0] != 2'b00;
    live[1]   = els[1] != 2'b00 && !buf_en;
    cmpv[0]   = bufm ? act : val[0];
    cmpv[1]   = val[1];
    for (int i = 0; i < 2; i++) begin
      cmp_on[i] = live[i] && (msa[i] || (i == 0 && bufm));
      cap_on[i] = live[i] && !cmp_on[i];
      hit[i] = cap_on[i] ? ((els[i][0] && sy[i][1] && !sy[i][2]) ||
                            (els[i][1] && !sy[i][1] && sy[i][2]))
                         : (cmp_on[i] && tick && cnt == cmpv[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      modv   <= '1;
      stop   <= 1'b0;
      act    <= '0;
      bsel   <= 1'b1;
      buf_en <= 1'b0;
    end else begin
      if (wr_en && addr == A_CTL) stop <= wdata[0];
      if (wr_en && addr == A_MOD) modv <= wdata;
      if (wr_sc[0]) buf_en <= wdata[3];
      if (clr) cnt <= '0;
      else if (!stop) cnt <= wrap ? '0 : cnt + ONE;
      if (!bufm) begin
        act  <= val[0];
        bsel <= 1'b1;
      end else if (tick && wrap) begin
        act  <= bsel ? val[1] : val[0];
        bsel <= !bsel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      els  <= '0;
      msa  <= '0;
      ie   <= '0;
      flag <= '0;
      arm  <= '0;
      outq <= '0;
      val  <= '0;
      sy   <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        sy[i] <= {sy[i][1:0], pin_in[i]};
        if (wr_sc[i]) begin
          els[i] <= wdata[1:0];
          msa[i] <= wdata[2];
          ie[i]  <= wdata[4];
        end
        arm[i] <= wr_sc[i] ? 1'b0 : (arm[i] | (rd_sc[i] & flag[i]));
        if (hit[i]) flag[i] <= 1'b1;
        else if (wr_sc[i] && arm[i] && !wdata[5]) flag[i] <= 1'b0;
        if (hit[i] && cap_on[i]) val[i] <= cnt;
        else if (wr_val[i]) val[i] <= wdata;
        if (els[i] == 2'b00) outq[i] <= !msa[i];
        else if (hit[i] && cmp_on[i]) begin
          case (els[i])
            2'b01:   outq[i] <= !outq[i];
            2'b10:   outq[i] <= 1'b0;
            default: outq[i] <= 1'b1;
          endcase
        end
      end
    end
  end

  always_comb begin
    unique case (addr)
      A_CTL:   rdata = {{(CW-2){1'b0}}, 1'b0, stop};
      A_MOD:   rdata = modv;
      A_CNT:   rdata = cnt;
      A_SC0:   rdata = {{(CW-6){1'b0}}, flag[0], ie[0], buf_en, msa[0], els[0]};
      A_VAL0:  rdata = val[0];
      A_SC1:   rdata = {{(CW-6){1'b0}}, flag[1], ie[1], 1'b0, msa[1], els[1]};
      A_VAL1:  rdata = val[1];
      default: rdata = '0;
    endcase
  end

  assign pin_out = outq;
  assign pin_oe  = cmp_on;
  assign irq     = flag & ie;

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop && !clr && cnt != modv) |=> cnt == $past(cnt) + ONE);
  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop && !clr && cnt == modv) |=> cnt == '0);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !clr) |=> $stable(cnt));
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
  assert_init_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (els[0] == 2'b00) |=> pin_out[0] == !$past(msa[0]));
  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[0] && !arm[0]) |=> flag[0]);
  assert_ch1_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_en |=> (!$rose(flag[1]) && !pin_oe[1]));
endmodule

// File: tb/dual_capcmp_timer_bench.sv
module dual_capcmp_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CTL = 3'd0, A_MOD = 3'd1, A_CNT = 3'd2,
                         A_SC0 = 3'd3, A_VAL0 = 3'd4, A_SC1 = 3'd5, A_VAL1 = 3'd6;
  // {edge field[1:0], pin start, pin end, expected flag}
  localparam logic [4:0] CAP_TBL [6] = '{5'b01_0_1_1, 5'b01_1_0_0, 5'b10_0_1_0,
                                         5'b10_1_0_1, 5'b11_0_1_1, 5'b11_1_0_1};

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0, rdata, d;
  logic [1:0] pin_in = '0, pin_out, pin_oe, irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_capcmp_timer u_dual_capcmp_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] v);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  // counter advances m+2 times
  task automatic run(input int m);
    wr(A_CTL, 16'h0000);
    repeat (m) @(negedge clk);
    wr(A_CTL, 16'h0001);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(A_SC0, d);  chk("R1 sc0", d, 16'h0000);
    rd(A_SC1, d);  chk("R1 sc1", d, 16'h0000);
    rd(A_VAL0, d); chk("R1 val0", d, 16'h0000);
    rd(A_CTL, d);  chk("R1 ctl", d, 16'h0000);
    rd(A_MOD, d);  chk("R1 mod", d, 16'hFFFF);
    chk("R1 oe/irq", {12'd0, pin_oe, irq}, 16'h0000);

    // R2 / R3 counter
    wr(A_CTL, 16'h0003);
    rd(A_CNT, d);  chk("R3 clear", d, 16'h0000);
    wr(A_MOD, 16'h0003);
    run(7);
    rd(A_CNT, d);  chk("R2 count with wrap", d, 16'h0001);
    repeat (5) @(negedge clk);
    rd(A_CNT, d);  chk("R3 hold", d, 16'h0001);
    rd(A_CTL, d);  chk("R3 clear bit reads 0", d, 16'h0001);
    wr(A_MOD, 16'hFFFF);

    // R5 capture edge table (counter halted at 1)
    for (int k = 0; k < 6; k++) begin
      pin_in[0] = CAP_TBL[k][2];
      wr(A_SC0, {14'd0, CAP_TBL[k][4:3]});
      repeat (4) @(negedge clk);
      rd(A_SC0, d);
      wr(A_SC0, {14'd0, CAP_TBL[k][4:3]});
      pin_in[0] = CAP_TBL[k][1];
      repeat (4) @(negedge clk);
      rd(A_SC0, d);
      chk("R5 edge select flag", {15'd0, d[5]}, {15'd0, CAP_TBL[k][0]});
      chk("R5 capture oe low", {14'd0, pin_oe}, 16'h0000);
      if (CAP_TBL[k][0]) begin
        rd(A_VAL0, d); chk("R5 captured count", d, 16'h0001);
      end
    end

    // R7 / R8 flag and interrupt (flag0 set, read already armed it)
    wr(A_SC0, 16'h0033);
    @(negedge clk); chk("R8 irq with enable", {15'd0, irq[0]}, 16'h0001);
    wr(A_SC0, 16'h0013);
    @(negedge clk); chk("R7 write without read keeps flag", {15'd0, irq[0]}, 16'h0001);
    rd(A_SC0, d);
    wr(A_SC0, 16'h0013);
    @(negedge clk); chk("R7 read then write clears", {15'd0, irq[0]}, 16'h0000);
    wr(A_SC0, 16'h0023);
    pin_in[0] = ~pin_in[0];
    repeat (4) @(negedge clk);
    chk("R8 irq masked", {15'd0, irq[0]}, 16'h0000);
    rd(A_SC0, d);  chk("R8 flag still set", {15'd0, d[5]}, 16'h0001);

    // R5 channel 1 capture
    wr(A_SC1, 16'h0001);
    repeat (4) @(negedge clk);
    pin_in[1] = 1'b1;
    repeat (4) @(negedge clk);
    rd(A_VAL1, d); chk("R5 ch1 captured count", d, 16'h0001);

    // R4 / R6 unbuffered compare, modulo 19, compare 5
    wr(A_CTL, 16'h0003);
    wr(A_MOD, 16'd19);
    wr(A_VAL0, 16'd5);
    wr(A_SC0, 16'h0000); @(negedge clk);
    chk("R4 msa0 high level", {15'd0, pin_out[0]}, 16'h0001);
    chk("R4 released oe", {15'd0, pin_oe[0]}, 16'h0000);
    wr(A_SC0, 16'h0004); @(negedge clk);
    chk("R4 msa1 low level", {15'd0, pin_out[0]}, 16'h0000);
    wr(A_SC0, 16'h0005);
    chk("R6 compare oe", {15'd0, pin_oe[0]}, 16'h0001);
    run(10);
    chk("R6 toggle", {15'd0, pin_out[0]}, 16'h0001);
    rd(A_CNT, d);  chk("R2 count 12", d, 16'd12);
    wr(A_CTL, 16'h0003);
    wr(A_SC0, 16'h0000); @(negedge clk);
    wr(A_SC0, 16'h0006);
    run(10);
    chk("R6 clear on match", {15'd0, pin_out[0]}, 16'h0000);
    wr(A_CTL, 16'h0003);
    wr(A_SC0, 16'h0004); @(negedge clk);
    wr(A_SC0, 16'h0007);
    run(2);
    chk("R6 no match before compare", {15'd0, pin_out[0]}, 16'h0000);
    run(10);
    chk("R6 set on match", {15'd0, pin_out[0]}, 16'h0001);

    // R9 / R10 buffered, modulo 9, values 2 and 6
    wr(A_CTL, 16'h0003);
    wr(A_MOD, 16'd9);
    wr(A_VAL0, 16'd2);
    wr(A_VAL1, 16'd6);
    wr(A_SC0, 16'h0004); @(negedge clk);
    wr(A_SC0, 16'h000D);
    chk("R9 ch1 oe low", {15'd0, pin_oe[1]}, 16'h0000);
    run(13);
    chk("R10 one toggle in 15 steps", {15'd0, pin_out[0]}, 16'h0001);
    run(3);
    chk("R10 second period uses ch1 value", {15'd0, pin_out[0]}, 16'h0000);
    wr(A_VAL0, 16'd8);
    run(2);
    chk("R10 write deferred to wrap", {15'd0, pin_out[0]}, 16'h0001);
    wr(A_SC1, 16'h0015);
    wr(A_SC0, 16'h0000);
    rd(A_SC1, d);  chk("R9 ch1 write ignored", d, 16'h0021);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule